// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides, during the address phase of an I2C slave transfer, whether the slave is the target. It sees the bus as a stream of received bytes, each tagged as the first byte after a START or as a later byte. Separate one-cycle inputs report START (including repeated START) and STOP conditions. Bit sampling, acknowledge driving and clock stretching live elsewhere. This block only classifies the address.

Two 10-bit configured addresses feed two comparators. A 3-bit mode makes each comparator 7-bit, 10-bit or unused, or joins both into one inclusive range test. The general-call address and the SMBus alert response address each have their own enable and their own flag. When the address phase completes, the block latches the match flags and the received address with its read/write bit, clears the not-valid indication, and pulses address-valid for one cycle. Everything is cleared again at the next START or STOP.

Top module: `i2c_addr_match`

## Requirements
- R1: `mode_i` selects the comparators. Bit 0 gives the width of slot 0 (and of the range): 0 is 7-bit, 1 is 10-bit. Values 0 and 1 use slot 0 only. Values 2 to 5 use both slots, with slot 1 being 10-bit for 3 and 4 and 7-bit for 2 and 5. Values 6 and 7 are range modes.
- R2: A 7-bit compare uses only bits 6:0 of the configured address. Bits 9:7 have no effect on it.
- R3: A first byte of the form 11110 a9 a8 rw starts a 10-bit address. The next byte tagged as not-first supplies a7..a0. No flag, capture or valid pulse appears after the header byte alone.
- R4: `am0_o` reports a hit on slot 0. `am1_o` reports a hit on slot 1, or any range hit.
- R5: In range modes, `am1_o` is set when addr0 <= received <= addr1, both bounds included, unsigned, at the width given by R1. `am0_o` stays low.
- R6: `gc_o` is set for the 7-bit byte 8'h00 (address 0, write), and only when `gc_en_i` is high.
- R7: `alert_o` is set for the 7-bit byte 8'h19 (address 7'h0C, read), and only when `alert_en_i` is high.
- R8: `raddr_o` captures {3'b000, first byte} for a 7-bit address and {a9..a0, rw} for a 10-bit address. `raddr_nv_o` is 1 after reset, START and STOP, and 0 after a capture.
- R9: START or STOP clears all four flags and sets `raddr_nv_o`. A byte in the same cycle as a condition is ignored.
- R10: `addr_valid_o` is a one-cycle pulse, given once per address phase. Bytes that arrive before any START, after a STOP, or after the phase has completed are ignored.
- R11: Flags, capture and the pulse update on the clock edge that samples the completing byte, and are visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START or repeated START seen (one cycle) |
| stop_i | input | 1 | STOP seen (one cycle) |
| byte_valid_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| byte_first_i | input | 1 | 1: first byte after START, 0: later byte |
| addr0_i | input | 10 | Slot 0 address / range low bound |
| addr1_i | input | 10 | Slot 1 address / range high bound |
| mode_i | input | 3 | Match mode (R1) |
| gc_en_i | input | 1 | General-call match enable |
| alert_en_i | input | 1 | Alert response match enable |
| am0_o | output | 1 | Slot 0 match flag |
| am1_o | output | 1 | Slot 1 or range match flag |
| gc_o | output | 1 | General-call flag |
| alert_o | output | 1 | Alert response flag |
| raddr_o | output | 11 | Captured address with R/W in bit 0 |
| raddr_nv_o | output | 1 | Captured address not valid |
| addr_valid_o | output | 1 | Address phase complete pulse |

## Verification
A wrong phase state shows up as a missing or extra `addr_valid_o` pulse in the cycle after the offending byte. Examples are a valid pulse after a 10-bit header alone, or a data byte accepted after completion. A wrong comparator selection or a wrong header latch shows in the flag and `raddr_o` values in that same cycle. The reference model is compared against every output on every cycle, so any divergence is reported within one clock of its cause.

// File: rtl/aam_pkg.sv
package aam_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  typedef struct packed {
    logic s0_wide;   // slot 0 (and range) compares 10-bit
    logic s1_en;     // slot 1 compares
    logic s1_wide;   // slot 1 compares 10-bit
    logic rng;       // range mode
  } mode_cfg_t;

  function automatic mode_cfg_t mode_decode(input logic [2:0] m);
    mode_cfg_t c;
    c.rng     = m[2] & m[1];
    c.s0_wide = m[0];
    c.s1_en   = (m[2] | m[1]) & ~c.rng;
    c.s1_wide = m[2] ^ m[0];
    return c;
  endfunction
endpackage

// File: rtl/aam_phase.sv
module aam_phase
  import aam_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_first_i,
  output logic              done_o,
  output logic              wide_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rw_o
);
  localparam int HI_W = ADDR_W - BYTE_W;
  localparam int PRE_W = BYTE_W - HI_W - 1;
  localparam logic [PRE_W-1:0] HDR_PRE = '1 << 1; // 11110

  phase_e          phase_q;
  logic [HI_W-1:0] hi_q;
  logic            rw_q;
  logic            hdr, armed, take_first, take_second;

  assign hdr         = byte_i[BYTE_W-1 -: PRE_W] == HDR_PRE;
  assign armed       = phase_q != PH_IDLE;
  assign take_first  = !start_i && !stop_i && byte_valid_i && armed && byte_first_i;
  assign take_second = !start_i && !stop_i && byte_valid_i && (phase_q == PH_SECOND) && !byte_first_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      hi_q    <= '0;
      rw_q    <= 1'b0;
    end else if (start_i) begin
      phase_q <= PH_FIRST;
    end else if (stop_i) begin
      phase_q <= PH_IDLE;
    end else if (take_first) begin
      if (hdr) begin
        phase_q <= PH_SECOND;
        hi_q    <= byte_i[HI_W:1];
        rw_q    <= byte_i[0];
      end else begin
        phase_q <= PH_IDLE;
      end
    end else if (take_second) begin
      phase_q <= PH_IDLE;
    end
  end

  assign done_o = (take_first && !hdr) || take_second;
  assign wide_o = take_second;
  assign rw_o   = take_second ? rw_q : byte_i[0];
  assign addr_o = take_second ? {hi_q, byte_i}
                              : {{(ADDR_W-BYTE_W+1){1'b0}}, byte_i[BYTE_W-1:1]};
endmodule

// File: rtl/aam_slot.sv
module aam_slot #(
  parameter int ADDR_W  = 10,
  parameter int SHORT_W = 7
) (
  input  logic              en_i,
  input  logic              want_wide_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] ref_i,
  output logic              hit_o
);
  logic eq_long, eq_short;
  assign eq_long  = addr_i == ref_i;
  assign eq_short = addr_i[SHORT_W-1:0] == ref_i[SHORT_W-1:0];
  assign hit_o = en_i && (want_wide_i ? (wide_i && eq_long) : (!wide_i && eq_short));
endmodule

// File: rtl/aam_range.sv
module aam_range #(
  parameter int ADDR_W  = 10,
  parameter int SHORT_W = 7
) (
  input  logic              en_i,
  input  logic              want_wide_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  output logic              hit_o
);
  logic in_long, in_short;
  assign in_long  = (addr_i >= lo_i) && (addr_i <= hi_i);
  assign in_short = (addr_i[SHORT_W-1:0] >= lo_i[SHORT_W-1:0]) &&
                    (addr_i[SHORT_W-1:0] <= hi_i[SHORT_W-1:0]);
  assign hit_o = en_i && (want_wide_i ? (wide_i && in_long) : (!wide_i && in_short));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import aam_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int SHORT_W = 7,
  parameter int BYTE_W  = 8,
  parameter logic [BYTE_W-1:0] GC_BYTE    = 8'h00,
  parameter logic [BYTE_W-1:0] ALERT_BYTE = 8'h19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              byte_first_i,
  input  logic [9:0]        addr0_i,
  input  logic [9:0]        addr1_i,
  input  logic [2:0]        mode_i,
  input  logic              gc_en_i,
  input  logic              alert_en_i,
  output logic              am0_o,
  output logic              am1_o,
  output logic              gc_o,
  output logic              alert_o,
  output logic [10:0]       raddr_o,
  output logic              raddr_nv_o,
  output logic              addr_valid_o
);
  localparam int RADDR_W = ADDR_W + 1;
  localparam int NSLOT   = 2;

  mode_cfg_t            cfg;
  logic                 done, wide, rw;
  logic [ADDR_W-1:0]    addr;
  logic [ADDR_W-1:0]    refs [NSLOT];
  logic [NSLOT-1:0]     slot_en, slot_wide, slot_hit;
  logic                 rng_hit, short_ok;
  logic [BYTE_W-1:0]    short_byte;

  assign cfg = mode_decode(mode_i);

  aam_phase #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_phase (
    .clk_i, .rst_ni, .start_i, .stop_i, .byte_valid_i, .byte_i, .byte_first_i,
    .done_o(done), .wide_o(wide), .addr_o(addr), .rw_o(rw)
  );

  assign refs[0]      = addr0_i;
  assign refs[1]      = addr1_i;
  assign slot_en[0]   = !cfg.rng;
  assign slot_en[1]   = cfg.s1_en;
  assign slot_wide[0] = cfg.s0_wide;
  assign slot_wide[1] = cfg.s1_wide;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    aam_slot #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_slot (
      .en_i(slot_en[s]), .want_wide_i(slot_wide[s]), .wide_i(wide),
      .addr_i(addr), .ref_i(refs[s]), .hit_o(slot_hit[s])
    );
  end

  aam_range #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_range (
    .en_i(cfg.rng), .want_wide_i(cfg.s0_wide), .wide_i(wide), .addr_i(addr),
    .lo_i(addr0_i), .hi_i(addr1_i), .hit_o(rng_hit)
  );

  assign short_byte = {addr[SHORT_W-1:0], rw};
  assign short_ok   = !wide;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      am0_o        <= 1'b0;
      am1_o        <= 1'b0;
      gc_o         <= 1'b0;
      alert_o      <= 1'b0;
      raddr_o      <= '0;
      raddr_nv_o   <= 1'b1;
      addr_valid_o <= 1'b0;
    end else if (start_i || stop_i) begin
      am0_o        <= 1'b0;
      am1_o        <= 1'b0;
      gc_o         <= 1'b0;
      alert_o      <= 1'b0;
      raddr_nv_o   <= 1'b1;
      addr_valid_o <= 1'b0;
    end else begin
      addr_valid_o <= done;
      if (done) begin
        am0_o      <= slot_hit[0];
        am1_o      <= slot_hit[1] | rng_hit;
        gc_o       <= short_ok && gc_en_i && (short_byte == GC_BYTE);
        alert_o    <= short_ok && alert_en_i && (short_byte == ALERT_BYTE);
        raddr_o    <= RADDR_W'({addr, rw});
        raddr_nv_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aam_checker.sv
module aam_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        stop_i,
  input logic [2:0]  mode_i,
  input logic        gc_en_i,
  input logic        alert_en_i,
  input logic        am0_o,
  input logic        am1_o,
  input logic        gc_o,
  input logic        alert_o,
  input logic        raddr_nv_o,
  input logic        addr_valid_o
);
  a_r9_cond_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> (!am0_o && !am1_o && !gc_o && !alert_o && raddr_nv_o && !addr_valid_o));

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |=> !addr_valid_o);

  a_r8_valid_has_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> !raddr_nv_o);

  a_r6_gc_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gc_o) |-> $past(gc_en_i));

  a_r7_alert_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_o) |-> $past(alert_en_i));

  a_r1_single_slot_modes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && $past(mode_i[2:1]) == 2'b00) |-> !am1_o);

  a_r11_flags_move_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(am0_o) || $rose(am1_o)) |-> addr_valid_o);
endmodule

bind i2c_addr_match aam_checker u_chk (.*);

// File: tb/i2c_addr_match_test.sv
module i2c_addr_match_test;
  logic clk = 0, rst_n = 0;
  logic start = 0, stop = 0, bv = 0, first = 0, gc_en = 0, al_en = 0;
  logic [7:0] data = 0;
  logic [9:0] a0 = 0, a1 = 0;
  logic [2:0] mode = 0;
  logic am0, am1, gc, al, nv, av;
  logic [10:0] raddr;
  int tests = 0, fails = 0;
  bit  over = 0;

  always #5 clk = ~clk;

  i2c_addr_match uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .byte_valid_i(bv), .byte_i(data), .byte_first_i(first),
    .addr0_i(a0), .addr1_i(a1), .mode_i(mode), .gc_en_i(gc_en), .alert_en_i(al_en),
    .am0_o(am0), .am1_o(am1), .gc_o(gc), .alert_o(al), .raddr_o(raddr),
    .raddr_nv_o(nv), .addr_valid_o(av)
  );

  // reference model
  int e_am0, e_am1, e_gc, e_al, e_nv, e_av, e_raddr;
  int m_armed, m_pend, m_hi, m_rw;

  function automatic int same(int is10, int want10, int a, int r);
    if (is10 != want10) return 0;
    return want10 ? int'(a == r) : int'(a == (r % 128));
  endfunction

  task automatic finish_addr(int is10, int a, int rw, int raw);
    int h0, h1, lo, hi;
    h0 = 0; h1 = 0;
    case (mode)
      3'd0: h0 = same(is10, 0, a, a0);
      3'd1: h0 = same(is10, 1, a, a0);
      3'd2: begin h0 = same(is10, 0, a, a0); h1 = same(is10, 0, a, a1); end
      3'd3: begin h0 = same(is10, 1, a, a0); h1 = same(is10, 1, a, a1); end
      3'd4: begin h0 = same(is10, 0, a, a0); h1 = same(is10, 1, a, a1); end
      3'd5: begin h0 = same(is10, 1, a, a0); h1 = same(is10, 0, a, a1); end
      3'd6: begin lo = a0 % 128; hi = a1 % 128; h1 = int'(is10 == 0 && a >= lo && a <= hi); end
      default: h1 = int'(is10 == 1 && a >= a0 && a <= a1);
    endcase
    e_am0 = h0; e_am1 = h1;
    e_gc  = int'(is10 == 0 && raw == 0 && gc_en);
    e_al  = int'(is10 == 0 && raw == 'h19 && al_en);
    e_raddr = is10 ? a * 2 + rw : raw;
    e_nv = 0; e_av = 1; m_armed = 0; m_pend = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_am0 = 0; e_am1 = 0; e_gc = 0; e_al = 0; e_nv = 1; e_av = 0; e_raddr = 0;
      m_armed = 0; m_pend = 0; m_hi = 0; m_rw = 0;
    end else begin
      e_av = 0;
      if (start || stop) begin
        e_am0 = 0; e_am1 = 0; e_gc = 0; e_al = 0; e_nv = 1;
        m_armed = int'(start); m_pend = 0;
      end else if (bv && m_armed != 0) begin
        if (first) begin
          if (data[7:3] == 5'b11110) begin
            m_pend = 1; m_hi = int'(data[2:1]); m_rw = int'(data[0]);
          end else finish_addr(0, int'(data[7:1]), int'(data[0]), int'(data));
        end else if (m_pend != 0) finish_addr(1, m_hi * 256 + int'(data), m_rw, int'(data));
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !over) begin
    chk("R4 am0", int'(am0), e_am0);
    chk("R4 am1", int'(am1), e_am1);
    chk("R6 gc", int'(gc), e_gc);
    chk("R7 alert", int'(al), e_al);
    chk("R8 raddr", int'(raddr), e_raddr);
    chk("R8 nv", int'(nv), e_nv);
    chk("R10 valid", int'(av), e_av);
  end

  task automatic cyc(); @(negedge clk); endtask
  task automatic do_start(); start = 1; cyc(); start = 0; endtask
  task automatic do_stop();  stop = 1;  cyc(); stop = 0;  endtask
  task automatic send(logic [7:0] b, logic f);
    data = b; first = f; bv = 1; cyc(); bv = 0; first = 0;
  endtask
  task automatic addr7(logic [7:0] b); do_start(); send(b, 1); endtask
  task automatic addr10(logic [7:0] h, logic [7:0] l); do_start(); send(h, 1); send(l, 0); endtask

  initial begin
    #1_000_000;
    if (!over) begin
      over = 1; tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    chk("R8 reset nv", int'(nv), 1);
    chk("R9 reset flags", int'({am0, am1, gc, al, av}), 0);
    rst_n = 1; cyc();

    // R10: byte before any START ignored
    send(8'h54, 1);
    chk("R10 no start", int'({av, nv}), 1);

    // R1/R2: mode 0, upper bits of addr0 ignored
    mode = 3'd0; a0 = 10'h3AA;
    addr7(8'h54);
    chk("R1 mode0 am0", int'(am0), 1);
    chk("R11 pulse", int'(av), 1);
    chk("R8 raddr7", int'(raddr), 'h054);
    cyc();
    chk("R10 pulse once", int'(av), 0);
    send(8'h54, 0); send(8'h54, 1);
    chk("R10 after done", int'({av, am0}), 1);

    // R4: mode 2 slot 1
    mode = 3'd2; a1 = 10'h015;
    addr7(8'h2B);
    chk("R4 slot1", int'({am0, am1}), 1);

    // R3: 10-bit mode 1
    mode = 3'd1; a0 = 10'h2C5;
    do_start(); send(8'hF4, 1);
    chk("R3 header only", int'({av, am0, nv}), 1);
    send(8'hC5, 0);
    chk("R3 10bit hit", int'(am0), 1);
    chk("R8 raddr10", int'(raddr), 'h58A);
    addr10(8'hF4, 8'hC4);
    chk("R3 10bit miss", int'({av, am0}), 2);

    // R1 mode 3, read
    mode = 3'd3; a1 = 10'h1FF;
    addr10(8'hF3, 8'hFF);
    chk("R1 mode3 am1", int'({am0, am1}), 1);
    chk("R8 raddr rw", int'(raddr), 'h3FF);

    // R1 mode 4 / 5
    mode = 3'd4; a0 = 10'h011; a1 = 10'h2C5;
    addr7(8'h22);  chk("R1 mode4 s0", int'({am0, am1}), 2);
    addr10(8'hF4, 8'hC5); chk("R1 mode4 s1", int'({am0, am1}), 1);
    mode = 3'd5; a0 = 10'h2C5; a1 = 10'h011;
    addr7(8'h22);  chk("R1 mode5 s1", int'({am0, am1}), 1);
    addr10(8'hF4, 8'hC5); chk("R1 mode5 s0", int'({am0, am1}), 2);

    // R5 range 7-bit
    mode = 3'd6; a0 = 10'h310; a1 = 10'h020;
    addr7(8'h20); chk("R5 low edge", int'({am0, am1}), 1);
    addr7(8'h41); chk("R5 high edge", int'(am1), 1);
    addr7(8'h42); chk("R5 above", int'(am1), 0);
    addr7(8'h1E); chk("R5 below", int'(am1), 0);
    // R5 range 10-bit
    mode = 3'd7; a0 = 10'h100; a1 = 10'h180;
    addr10(8'hF2, 8'h80); chk("R5 10 edge", int'(am1), 1);
    addr10(8'hF2, 8'h81); chk("R5 10 above", int'(am1), 0);
    addr10(8'hF2, 8'h00); chk("R5 10 low", int'(am1), 1);

    // R6 general call
    mode = 3'd0; a0 = 10'h050;
    addr7(8'h00); chk("R6 gc off", int'(gc), 0);
    gc_en = 1;
    addr7(8'h00); chk("R6 gc on", int'(gc), 1);
    addr7(8'h01); chk("R6 gc read", int'(gc), 0);

    // R7 alert
    addr7(8'h19); chk("R7 alert off", int'(al), 0);
    al_en = 1;
    addr7(8'h19); chk("R7 alert on", int'(al), 1);
    addr7(8'h18); chk("R7 alert write", int'(al), 0);

    // R9 clear on STOP and START, byte with START ignored
    addr7(8'hA0); chk("R9 set", int'(am0), 1);
    do_stop(); chk("R9 stop clears", int'({am0, nv}), 1);
    send(8'hA0, 1); chk("R10 after stop", int'({av, am0}), 0);
    start = 1; data = 8'hA0; first = 1; bv = 1; cyc();
    start = 0; bv = 0; first = 0;
    chk("R9 same cycle", int'({av, am0, nv}), 1);
    send(8'hA0, 1); chk("R9 next byte ok", int'(am0), 1);
    do_start(); chk("R9 start clears", int'({am0, nv}), 1);

    cyc(); cyc();
    if (!over) begin
      over = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule